// File: doc/BRIEF.md
# Pipelined Burst SRAM Cycle Controller

This block sits in front of the storage array of a pipelined synchronous burst SRAM. On every clock edge it samples the chip selects, the two burst-start strobes (one from a processor, one from a controller), the advance input, the write controls and the sleep request. From these it classifies the cycle as a deselect, a read burst start, a write burst start, a step to the next burst address or a hold at the current address. It then drives the controls that the address sequencer and the array need for that cycle.

All of its outputs except the data-bus enable are registered. They are valid for the clock period after the edge that sampled the command. Read data leaves through a pipelined output register, so the data-bus enable follows a read command by two edges. That enable is also gated asynchronously by the output-enable pin and by the sleep request. A sleep request overrides every other input. The block models the delay into the low-power state and the recovery delay back out of it.

Top module: `sram_burst_ctl`

## Requirements
- R1: A deselect occurs when `sel_a_n` is high and `ctl_start_n` is low, or when `sel_a_n` is low, either start strobe is low and the chip is not fully selected (`sel_b` low or `sel_c_n` high). A deselect raises no load, no step and no byte strobe. It ends the burst, so that later continue or hold cycles do nothing until a new burst begins.
- R2: The chip is fully selected when `sel_a_n` is low, `sel_b` is high and `sel_c_n` is low. When it is fully selected and `cpu_start_n` is low, the cycle starts a read burst: `addr_load` is high after that edge and `byte_we` is 0000, whatever the write inputs are.
- R3: When the chip is fully selected, `cpu_start_n` is high and `ctl_start_n` is low, a burst starts with `addr_load` high. It is a write when the combined write of R4 is active and a read otherwise.
- R4: The combined write is active when `wr_all_n` is low, or when `wr_en_n` is low and at least one bit of `wr_byte_n` is low. With `wr_all_n` high and either `wr_en_n` high or `wr_byte_n` equal to 1111, the cycle is a read.
- R5: In a write cycle, `byte_we` is 1111 when `wr_all_n` is low. Otherwise it is the inverse of `wr_byte_n`, with bit i controlling byte i.
- R6: A continue cycle has `next_n` low and no burst start: either both start strobes are high, or `sel_a_n` is high with `ctl_start_n` high, in which case `cpu_start_n` is ignored. Inside an active burst, a continue cycle raises `addr_step` after that edge. It writes when the combined write is active and reads otherwise.
- R7: A hold cycle matches a continue cycle except that `next_n` is high. Inside an active burst it raises neither `addr_load` nor `addr_step`, and it reads or writes at the current address.
- R8: `data_drive` rises in the clock period after the one in which a read cycle's controls appear, which is two edges after the command. It is high only while `out_en_n` is low, and it follows `out_en_n` without waiting for a clock.
- R9: `data_drive` is low whenever `byte_we` is nonzero.
- R10: While `sleep_req` is high, `data_drive` is low at once and every command is ignored. After each edge that samples `sleep_req` high, `addr_load`, `addr_step` and `byte_we` are zero, and any active burst is ended.
- R11: `snoozing` rises after the second consecutive edge that samples `sleep_req` high. It falls after the first edge that samples it low.
- R12: Commands sampled on the first two edges with `sleep_req` low after a sleep are ignored. The third such edge accepts a command.
- R13: While `rst_n` is low, all outputs are low and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_a_n | input | 1 | Chip select A, active low |
| sel_b | input | 1 | Chip select B, active high |
| sel_c_n | input | 1 | Chip select C, active low |
| sleep_req | input | 1 | Sleep request, overrides all other inputs |
| cpu_start_n | input | 1 | Processor burst-start strobe, active low, always a read |
| ctl_start_n | input | 1 | Controller burst-start strobe, active low |
| next_n | input | 1 | Advance to the next burst address, active low |
| wr_all_n | input | 1 | Write all bytes, active low |
| wr_en_n | input | 1 | Per-byte write enable, active low |
| wr_byte_n | input | NBYTE | Per-byte write selects, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| addr_load | output | 1 | Load the external address into the burst counter |
| addr_step | output | 1 | Advance the burst counter |
| byte_we | output | NBYTE | Per-byte write strobes to the array |
| data_drive | output | 1 | Drive the data bus |
| snoozing | output | 1 | Low-power state reached |

## Verification
A wrong burst-active flag appears at the ports on the first continue or hold cycle after a deselect or a sleep, as a false `addr_step` or a false byte strobe in the next clock period. A wrong read-pipeline bit shows as `data_drive` asserted or missing one period after the read controls. A wrong recovery count lets a command through, or blocks one, on the first edges after `sleep_req` falls, and this appears within one period as `addr_load`. The bench sweeps every combination of the control inputs in one continuous sequence, so the decode is exercised from many burst states, and a model written from the requirements predicts each output cycle by cycle.

// File: rtl/sram_ctl_pkg.sv
// Shared types for the burst SRAM cycle controller.
// Assumes: one cycle classification per clock edge.
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        CK_DESEL    = 3'd0,
        CK_RD_BEGIN = 3'd1,
        CK_WR_BEGIN = 3'd2,
        CK_NEXT     = 3'd3,
        CK_HOLD     = 3'd4
    } cyc_kind_e;

endpackage

// File: rtl/sram_cmd_decode.sv
// Combinational classification of the sampled control inputs into a cycle
// kind, plus the combined write flag and the per-byte write mask.
// Assumes: inputs are stable around the clock edge; sleep is handled elsewhere.
module sram_cmd_decode
    import sram_ctl_pkg::*;
#(
    parameter int NBYTE = 4
) (
    input  logic             sel_a_n,
    input  logic             sel_b,
    input  logic             sel_c_n,
    input  logic             cpu_start_n,
    input  logic             ctl_start_n,
    input  logic             next_n,
    input  logic             wr_all_n,
    input  logic             wr_en_n,
    input  logic [NBYTE-1:0] wr_byte_n,
    output cyc_kind_e        kind,
    output logic             wr_low,
    output logic [NBYTE-1:0] wr_mask
);

    logic full_sel;
    logic [NBYTE-1:0] sel_bytes;

    assign full_sel = !sel_a_n && sel_b && !sel_c_n;

    // Byte strobes chosen by the per-byte enable path.
    genvar gi;
    generate
        for (gi = 0; gi < NBYTE; gi++) begin : g_byte
            assign sel_bytes[gi] = !wr_en_n && !wr_byte_n[gi];
        end
    endgenerate

    // Combined write flag and byte mask; the global write covers every byte.
    always_comb begin
        wr_low  = !wr_all_n || (|sel_bytes);
        wr_mask = !wr_all_n ? {NBYTE{1'b1}} : sel_bytes;
    end

    // Cycle kind in priority order: select A high, processor start, controller start, continue.
    always_comb begin
        if (sel_a_n) begin
            if (!ctl_start_n)      kind = CK_DESEL;
            else if (!next_n)      kind = CK_NEXT;
            else                   kind = CK_HOLD;
        end else if (!cpu_start_n) begin
            kind = full_sel ? CK_RD_BEGIN : CK_DESEL;
        end else if (!ctl_start_n) begin
            if (!full_sel)         kind = CK_DESEL;
            else if (wr_low)       kind = CK_WR_BEGIN;
            else                   kind = CK_RD_BEGIN;
        end else begin
            kind = next_n ? CK_HOLD : CK_NEXT;
        end
    end

endmodule

// File: rtl/sram_snooze_ctl.sv
// Sleep-mode timing: counts consecutive sleep edges to report the low-power
// state and blocks commands during the recovery window after sleep ends.
// Assumes: sleep_req is synchronous to clk when sampled.
module sram_snooze_ctl #(
    parameter int ENTRY_CYC = 2,
    parameter int RECOV_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    output logic accept,
    output logic snoozing
);

    localparam int EW = $clog2(ENTRY_CYC + 1);
    localparam int RW = $clog2(RECOV_CYC + 1);
    localparam logic [EW-1:0] ENT_MAX = EW'(ENTRY_CYC);
    localparam logic [RW-1:0] REC_MAX = RW'(RECOV_CYC);

    logic [EW-1:0] ent_cnt;
    logic [RW-1:0] rec_cnt;

    // Count sleep edges toward the low-power state; arm and drain the recovery window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_cnt <= '0;
            rec_cnt <= '0;
        end else if (sleep_req) begin
            rec_cnt <= REC_MAX;
            if (ent_cnt != ENT_MAX) ent_cnt <= ent_cnt + 1'b1;
        end else begin
            ent_cnt <= '0;
            if (rec_cnt != '0) rec_cnt <= rec_cnt - 1'b1;
        end
    end

    assign accept   = !sleep_req && (rec_cnt == '0);
    assign snoozing = (ent_cnt == ENT_MAX);

endmodule

// File: rtl/sram_cycle_pipe.sv
// Registers the per-cycle controls, tracks whether a burst is active, and
// runs the two-stage read pipeline behind the asynchronous bus enable.
// Assumes: kind/wr_low/wr_mask come from the decoder for the same edge.
module sram_cycle_pipe
    import sram_ctl_pkg::*;
#(
    parameter int NBYTE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  cyc_kind_e        kind,
    input  logic             wr_low,
    input  logic [NBYTE-1:0] wr_mask,
    input  logic             sleep_req,
    input  logic             out_en_n,
    output logic             addr_load,
    output logic             addr_step,
    output logic [NBYTE-1:0] byte_we,
    output logic             data_drive
);

    logic burst_on;
    logic rd_addr_q;
    logic rd_data_q;
    logic cont;
    logic do_wr;

    // Continue or hold inside a live burst.
    assign cont  = ((kind == CK_NEXT) || (kind == CK_HOLD)) && burst_on;
    assign do_wr = (kind == CK_WR_BEGIN) || (cont && wr_low);

    // Register the address, write and read-stage controls for the accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_load <= 1'b0;
            addr_step <= 1'b0;
            byte_we   <= '0;
            rd_addr_q <= 1'b0;
            burst_on  <= 1'b0;
        end else if (!accept) begin
            addr_load <= 1'b0;
            addr_step <= 1'b0;
            byte_we   <= '0;
            rd_addr_q <= 1'b0;
            burst_on  <= 1'b0;
        end else begin
            addr_load <= (kind == CK_RD_BEGIN) || (kind == CK_WR_BEGIN);
            addr_step <= (kind == CK_NEXT) && burst_on;
            byte_we   <= do_wr ? wr_mask : '0;
            rd_addr_q <= (kind == CK_RD_BEGIN) || (cont && !wr_low);
            if ((kind == CK_RD_BEGIN) || (kind == CK_WR_BEGIN)) burst_on <= 1'b1;
            else if (kind == CK_DESEL)                          burst_on <= 1'b0;
        end
    end

    // Output register stage of the read pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data_q <= 1'b0;
        else        rd_data_q <= rd_addr_q;
    end

    // Bus enable: asynchronous in out_en_n and sleep_req, masked during writes.
    assign data_drive = rd_data_q && !out_en_n && !sleep_req && (byte_we == '0);

endmodule

// File: rtl/sram_burst_ctl.sv
// Top of the burst SRAM cycle controller: decoder, sleep timer and control
// pipeline. Assumes a single clock and synchronous active-low reset.
module sram_burst_ctl
    import sram_ctl_pkg::*;
#(
    parameter int NBYTE     = 4,
    parameter int ENTRY_CYC = 2,
    parameter int RECOV_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_a_n,
    input  logic             sel_b,
    input  logic             sel_c_n,
    input  logic             sleep_req,
    input  logic             cpu_start_n,
    input  logic             ctl_start_n,
    input  logic             next_n,
    input  logic             wr_all_n,
    input  logic             wr_en_n,
    input  logic [NBYTE-1:0] wr_byte_n,
    input  logic             out_en_n,
    output logic             addr_load,
    output logic             addr_step,
    output logic [NBYTE-1:0] byte_we,
    output logic             data_drive,
    output logic             snoozing
);

    cyc_kind_e        kind;
    logic             wr_low;
    logic [NBYTE-1:0] wr_mask;
    logic             cmd_ok;

    sram_cmd_decode #(.NBYTE(NBYTE)) u_dec (
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .cpu_start_n(cpu_start_n), .ctl_start_n(ctl_start_n), .next_n(next_n),
        .wr_all_n(wr_all_n), .wr_en_n(wr_en_n), .wr_byte_n(wr_byte_n),
        .kind(kind), .wr_low(wr_low), .wr_mask(wr_mask)
    );

    sram_snooze_ctl #(.ENTRY_CYC(ENTRY_CYC), .RECOV_CYC(RECOV_CYC)) u_zz (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
        .accept(cmd_ok), .snoozing(snoozing)
    );

    sram_cycle_pipe #(.NBYTE(NBYTE)) u_pipe (
        .clk(clk), .rst_n(rst_n), .accept(cmd_ok), .kind(kind),
        .wr_low(wr_low), .wr_mask(wr_mask), .sleep_req(sleep_req),
        .out_en_n(out_en_n), .addr_load(addr_load), .addr_step(addr_step),
        .byte_we(byte_we), .data_drive(data_drive)
    );

endmodule

// File: rtl/sram_burst_ctl_chk.sv
// Assertion checker for sram_burst_ctl, attached through bind.
module sram_burst_ctl_chk #(
    parameter int NBYTE = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel_a_n,
    input logic             sel_b,
    input logic             sel_c_n,
    input logic             sleep_req,
    input logic             cpu_start_n,
    input logic             ctl_start_n,
    input logic             addr_load,
    input logic             addr_step,
    input logic [NBYTE-1:0] byte_we,
    input logic             data_drive,
    input logic             snoozing,
    input logic             cmd_ok
);

    p_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ok && sel_a_n && !ctl_start_n) |=> (!addr_load && !addr_step && byte_we == '0));

    p_cpu_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ok && !sel_a_n && sel_b && !sel_c_n && !cpu_start_n) |=> (addr_load && byte_we == '0));

    p_load_or_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_load && addr_step));

    p_write_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_we != '0) |-> !data_drive);

    p_sleep_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |=> (!addr_load && !addr_step && byte_we == '0));

    p_sleep_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> !data_drive);

    p_snooze_entry_r11: assert property (@(posedge clk) disable iff (!rst_n)
        snoozing |-> $past(sleep_req));

    p_recovery_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sleep_req) |-> !cmd_ok);

endmodule

bind sram_burst_ctl sram_burst_ctl_chk #(.NBYTE(NBYTE)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .sleep_req(sleep_req), .cpu_start_n(cpu_start_n), .ctl_start_n(ctl_start_n),
    .addr_load(addr_load), .addr_step(addr_step), .byte_we(byte_we),
    .data_drive(data_drive), .snoozing(snoozing), .cmd_ok(cmd_ok)
);

// File: tb/sim_sram_burst_ctl.sv
// Self-checking bench: directed cases plus an exhaustive control sweep and a
// pseudo-random phase with sleep, against a model built from the requirements.
module sim_sram_burst_ctl;

    localparam int NB  = 4;
    localparam int ENT = 2;
    localparam int REC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_a_n, sel_b, sel_c_n, sleep_req, cpu_start_n, ctl_start_n, next_n;
    logic wr_all_n, wr_en_n, out_en_n;
    logic [NB-1:0] wr_byte_n;
    logic addr_load, addr_step, data_drive, snoozing;
    logic [NB-1:0] byte_we;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // model state
    logic m_load, m_step, m_active, m_rd1, m_rd2;
    logic [NB-1:0] m_we;
    int m_ent, m_rec;

    sram_burst_ctl #(.NBYTE(NB), .ENTRY_CYC(ENT), .RECOV_CYC(REC)) u0 (
        .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .sleep_req(sleep_req), .cpu_start_n(cpu_start_n), .ctl_start_n(ctl_start_n),
        .next_n(next_n), .wr_all_n(wr_all_n), .wr_en_n(wr_en_n), .wr_byte_n(wr_byte_n),
        .out_en_n(out_en_n), .addr_load(addr_load), .addr_step(addr_step),
        .byte_we(byte_we), .data_drive(data_drive), .snoozing(snoozing)
    );

    always #5 clk = ~clk;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // bits: [12]oe [11:8]bytes [7]wr_en [6]wr_all [5]next [4]ctl [3]cpu [2]sel_c_n [1]sel_b [0]sel_a_n
    function automatic logic [12:0] cmd(input logic a_n, input logic b, input logic c_n,
                                        input logic cpu, input logic ctl, input logic nx,
                                        input logic ga, input logic be, input logic [3:0] bw,
                                        input logic oe);
        return {oe, bw, be, ga, nx, ctl, cpu, c_n, b, a_n};
    endfunction

    task automatic model_edge(input logic [12:0] v, input logic slp);
        logic acc, full, wlow, rdb, wrb, nxt, hld, des, cont;
        logic [NB-1:0] mask;
        acc  = !slp && (m_rec == 0);
        full = !v[0] && v[1] && !v[2];
        wlow = !v[6] || (!v[7] && (v[11:8] != 4'hF));        // R4
        mask = !v[6] ? 4'hF : (!v[7] ? ~v[11:8] : 4'h0);     // R5
        rdb = 0; wrb = 0; nxt = 0; hld = 0; des = 0;
        if (v[0]) begin
            if (!v[4]) des = 1; else if (!v[5]) nxt = 1; else hld = 1;
        end else if (!v[3]) begin
            if (full) rdb = 1; else des = 1;
        end else if (!v[4]) begin
            if (!full) des = 1; else if (wlow) wrb = 1; else rdb = 1;
        end else begin
            if (v[5]) hld = 1; else nxt = 1;
        end
        cont = (nxt || hld) && m_active;
        m_rd2 = m_rd1;
        if (!acc) begin
            m_load = 0; m_step = 0; m_we = 0; m_rd1 = 0; m_active = 0;
        end else begin
            m_load = rdb || wrb;
            m_step = nxt && m_active;
            m_we   = (wrb || (cont && wlow)) ? mask : 4'h0;
            m_rd1  = rdb || (cont && !wlow);
            if (rdb || wrb) m_active = 1; else if (des) m_active = 0;
        end
        if (slp) begin
            m_rec = REC;
            if (m_ent < ENT) m_ent++;
        end else begin
            m_ent = 0;
            if (m_rec > 0) m_rec--;
        end
    endtask

    task automatic compare_all();
        logic exp_drv;
        exp_drv = m_rd2 && !out_en_n && !sleep_req && (m_we == 4'h0);
        chk(addr_load === m_load, "R2/R3 addr_load", int'(addr_load), int'(m_load));
        chk(addr_step === m_step, "R6 addr_step", int'(addr_step), int'(m_step));
        chk(byte_we === m_we, "R5 byte_we", int'(byte_we), int'(m_we));
        chk(data_drive === exp_drv, "R8 data_drive", int'(data_drive), int'(exp_drv));
        chk(snoozing === (m_ent == ENT), "R11 snoozing", int'(snoozing), int'(m_ent == ENT));
    endtask

    // Drive at the negedge, model the edge, compare at the following negedge.
    task automatic apply(input logic [12:0] v, input logic slp);
        {out_en_n, wr_byte_n, wr_en_n, wr_all_n, next_n, ctl_start_n, cpu_start_n,
         sel_c_n, sel_b, sel_a_n} = v;
        sleep_req = slp;
        @(posedge clk);
        model_edge(v, slp);
        @(negedge clk);
        compare_all();
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [12:0] idle;
        logic [15:0] lfsr;
        idle = cmd(1, 0, 1, 1, 1, 1, 1, 1, 4'hF, 1);
        {out_en_n, wr_byte_n, wr_en_n, wr_all_n, next_n, ctl_start_n, cpu_start_n,
         sel_c_n, sel_b, sel_a_n} = idle;
        sleep_req = 1'b0;
        repeat (3) @(negedge clk);
        // R13: reset state
        chk({addr_load, addr_step, byte_we, data_drive, snoozing} == '0,
            "R13 reset outputs", int'({addr_load, addr_step, byte_we, data_drive, snoozing}), 0);
        m_load = 0; m_step = 0; m_we = 0; m_active = 0; m_rd1 = 0; m_rd2 = 0;
        m_ent = 0; m_rec = 0;
        rst_n = 1'b1;

        // R2: processor start reads even with global write low
        apply(cmd(0, 1, 0, 0, 1, 1, 0, 0, 4'h0, 0), 0);
        chk(addr_load && byte_we == 0, "R2 cpu start read", int'({addr_load, byte_we}), 5'h10);
        // R3/R5/R9: controller write start, byte selects 1010 -> strobes 0101, read masked
        apply(cmd(0, 1, 0, 1, 0, 1, 1, 0, 4'b1010, 0), 0);
        chk(byte_we == 4'b0101, "R5 byte strobes", int'(byte_we), 5);
        chk(addr_load == 1'b1, "R3 write begin load", int'(addr_load), 1);
        chk(data_drive == 1'b0, "R9 masked during write", int'(data_drive), 0);
        // R7: hold with write, select A high -> writes current address, no load/step
        apply(cmd(1, 0, 1, 1, 1, 1, 1, 0, 4'b0111, 0), 0);
        chk(byte_we == 4'b1000 && !addr_load && !addr_step, "R7 hold write",
            int'({addr_load, addr_step, byte_we}), 8);
        // R4: byte enable low but all selects high -> read start
        apply(cmd(0, 1, 0, 1, 0, 1, 1, 0, 4'hF, 0), 0);
        chk(addr_load && byte_we == 0, "R4 read when no byte selected", int'({addr_load, byte_we}), 5'h10);
        // R6: select A high, processor strobe ignored, advance
        apply(cmd(1, 0, 1, 0, 1, 0, 1, 1, 4'hF, 0), 0);
        chk(addr_step == 1'b1, "R6 continue step", int'(addr_step), 1);
        chk(data_drive == 1'b1, "R8 read data one period later", int'(data_drive), 1);
        // R8: output enable acts without a clock
        out_en_n = 1'b1; #1;
        chk(data_drive == 1'b0, "R8 async disable", int'(data_drive), 0);
        out_en_n = 1'b0; #1;
        chk(data_drive == 1'b1, "R8 async enable", int'(data_drive), 1);
        // R1: deselect, then a continue does nothing
        apply(cmd(1, 0, 1, 1, 0, 1, 1, 1, 4'hF, 0), 0);
        chk(!addr_load && !addr_step, "R1 deselect", int'({addr_load, addr_step}), 0);
        apply(cmd(1, 0, 1, 1, 1, 0, 0, 1, 4'hF, 0), 0);
        chk(!addr_step && byte_we == 0, "R1 no burst after deselect", int'({addr_step, byte_we}), 0);
        // R1: partial select with processor start deselects
        apply(cmd(0, 0, 0, 0, 1, 1, 1, 1, 4'hF, 0), 0);
        chk(!addr_load, "R1 partial select", int'(addr_load), 0);

        // R10/R11/R12: sleep sequence
        apply(cmd(0, 1, 0, 0, 1, 1, 1, 1, 4'hF, 0), 0);
        apply(cmd(1, 0, 1, 1, 1, 1, 1, 1, 4'hF, 0), 0);
        chk(data_drive == 1'b1, "R8 read before sleep", int'(data_drive), 1);
        apply(cmd(0, 1, 0, 0, 1, 1, 1, 1, 4'hF, 0), 1);
        chk(!addr_load && !data_drive, "R10 sleep ignores and tri-states",
            int'({addr_load, data_drive}), 0);
        chk(!snoozing, "R11 not yet asleep", int'(snoozing), 0);
        apply(cmd(0, 1, 0, 0, 1, 1, 1, 1, 4'hF, 0), 1);
        chk(snoozing, "R11 asleep after two edges", int'(snoozing), 1);
        apply(cmd(0, 1, 0, 0, 1, 1, 1, 1, 4'hF, 0), 0);
        chk(!snoozing && !addr_load, "R12 first recovery edge", int'({snoozing, addr_load}), 0);
        apply(cmd(1, 0, 1, 1, 1, 0, 1, 1, 4'hF, 0), 0);
        chk(!addr_load && !addr_step, "R12 second recovery edge", int'({addr_load, addr_step}), 0);
        apply(cmd(1, 0, 1, 1, 1, 0, 1, 1, 4'hF, 0), 0);
        chk(!addr_step, "R10 burst ended by sleep", int'(addr_step), 0);
        apply(cmd(0, 1, 0, 0, 1, 1, 1, 1, 4'hF, 0), 0);
        chk(addr_load, "R12 accepted after recovery", int'(addr_load), 1);

        // exhaustive sweep of all 13 control bits, awake
        for (int n = 0; n < 8192; n++) apply(13'(n), 0);

        // pseudo-random phase with occasional sleep
        lfsr = 16'hACE1;
        for (int n = 0; n < 4000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            apply(lfsr[12:0] ^ 13'(n), (lfsr[15:13] == 3'b000));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule